// File: doc/BRIEF.md
# Predicated Issue Stage

This block is the issue and writeback-timing stage of an in-order pipeline in which every instruction names a predicate register as an extra source operand. The predicate decides whether the instruction does its work or passes down the pipe as a harmless bubble. Two kinds of instruction are handled: a predicated ALU operation and a conditional load. The conditional load reads memory at the address held in its base register only when the predicate is non-zero.

The predicate is an ordinary general register. Its value comes from an extra register-file read port, and a bypass path from writeback supplies it when it is being written in the same cycle. An external scoreboard provides one busy bit per register. When the predicate register is still pending and no bypass covers it, the stage holds the instruction in order. An if/else is usually compiled by writing the logical NOT of a condition into a fresh register, so that the two arms carry complementary predicates. The ALU datapath and the memory are outside the block. Writeback is modelled as a fixed number of cycles after issue.

Top module: `pred_issue_stage`

## Requirements
- R1: With a valid instruction whose predicate is ready and non-zero and whose needed sources are ready, the instruction issues (issueFire=1, stall=0) in that cycle. An ALU operation (instIsLoad=0) raises aluEnable, and a load (instIsLoad=1) raises memReadEn with memAddr equal to baseData.
- R2: A valid instruction whose predicate value is zero issues as a no-op. It raises neither aluEnable nor memReadEn, and its commit slot shows commitValid=1 with commitWriteEn=0.
- R3: When the predicate register is non-zero, its busy bit is set and it is not being forwarded, the stage asserts stall and deasserts issueFire, aluEnable and memReadEn.
- R4: When wbValid=1 and wbDest equals a non-zero predicate index, the predicate value is taken from wbData instead of predData, and the busy bit of that register does not stall the instruction.
- R5: Predicate index 0 always reads as zero, whatever predData, wbData or busy bit 0 show. Such an instruction never stalls and never executes.
- R6: An instruction whose predicate is true stalls while a needed source is busy. A load needs srcA only, an ALU operation needs srcA and srcB, and register 0 is never busy. An instruction with a false predicate ignores the busy bits of its sources.
- R7: Exactly LATENCY cycles after the cycle in which an instruction issues, commitValid=1, commitWriteEn shows whether it executed, and commitDest and commitIsLoad show its destination and kind. A cycle with no issue produces commitValid=0, commitWriteEn=0, commitDest=0 and commitIsLoad=0 in the same slot.
- R8: After reset, commitValid, commitWriteEn, commitDest and commitIsLoad are all zero.
- R9: With instValid=0 the stage raises none of stall, issueFire, aluEnable or memReadEn.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| instValid | input | 1 | Decoded instruction present |
| instIsLoad | input | 1 | 1 = conditional load, 0 = predicated ALU operation |
| instDest | input | $clog2(REGS) | Destination register index |
| instSrcA | input | $clog2(REGS) | First source (base register for a load) |
| instSrcB | input | $clog2(REGS) | Second source (ALU only) |
| instPred | input | $clog2(REGS) | Predicate register index |
| busyVec | input | REGS | Scoreboard busy bit per register |
| predData | input | DW | Register-file read of the predicate register |
| baseData | input | DW | Register-file read of srcA |
| wbValid | input | 1 | Writeback in progress this cycle |
| wbDest | input | $clog2(REGS) | Register being written back |
| wbData | input | DW | Value being written back |
| stall | output | 1 | Instruction held this cycle |
| issueFire | output | 1 | Instruction leaves the stage this cycle |
| aluEnable | output | 1 | Predicated ALU operation executes |
| memReadEn | output | 1 | Conditional load reads memory |
| memAddr | output | DW | Load address |
| commitValid | output | 1 | Commit slot holds an issued instruction |
| commitWriteEn | output | 1 | Register write enable at commit |
| commitDest | output | $clog2(REGS) | Register written at commit |
| commitIsLoad | output | 1 | Committed instruction was a load |

## Verification
The properties assume that the scoreboard and the register read ports are driven by a well-behaved pipeline. They also assume that REGS is a power of two, so that every index names a real busy bit. No property depends on the instruction being held steady while it stalls, because the stimulus changes the instruction every cycle whether or not it issued. The sweep covers every busy pattern of a four-register configuration together with every predicate index, every forwarding target, zero and non-zero predicate values and both instruction kinds. Instruction-valid is dropped regularly, so idle commit slots are checked as well.

// File: rtl/pred_issue_pkg.sv
package pred_issue_pkg;

  // Strobes passed from the issue control to the datapath.
  typedef struct packed {
    logic fire;    // instruction leaves the stage
    logic exec;    // it issued with a true predicate
    logic isLoad;  // kind of the instruction that fired
  } issue_strobe_t;

endpackage

// File: rtl/pred_issue_ctrl.sv
module pred_issue_ctrl
  import pred_issue_pkg::*;
#(
  parameter int REGS = 32,
  localparam int AW = $clog2(REGS)
) (
  input  logic            instValid,
  input  logic            instIsLoad,
  input  logic [AW-1:0]   instSrcA,
  input  logic [AW-1:0]   instSrcB,
  input  logic [AW-1:0]   instPred,
  input  logic [REGS-1:0] busyVec,
  input  logic            fwdHit,
  input  logic            predNonZero,
  output logic            stall,
  output issue_strobe_t   strobe
);

  logic predIsZero;
  logic predPending;
  logic predTrue;
  logic srcAPending;
  logic srcBPending;

  always_comb begin
    predIsZero  = (instPred == '0);
    predPending = !predIsZero && busyVec[instPred] && !fwdHit;
    predTrue    = !predIsZero && predNonZero;
    srcAPending = (instSrcA != '0) && busyVec[instSrcA];
    srcBPending = !instIsLoad && (instSrcB != '0) && busyVec[instSrcB];

    // Wait for the predicate first; wait for sources only if it is true.
    stall = instValid && (predPending || (predTrue && (srcAPending || srcBPending)));

    strobe.fire   = instValid && !stall;
    strobe.exec   = strobe.fire && predTrue;
    strobe.isLoad = strobe.fire && instIsLoad;
  end

endmodule

// File: rtl/pred_issue_dpath.sv
module pred_issue_dpath
  import pred_issue_pkg::*;
#(
  parameter int REGS    = 32,
  parameter int DW      = 32,
  parameter int LATENCY = 3,
  localparam int AW = $clog2(REGS)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [AW-1:0] instDest,
  input  logic [AW-1:0] instPred,
  input  logic [DW-1:0] predData,
  input  logic [DW-1:0] baseData,
  input  logic          wbValid,
  input  logic [AW-1:0] wbDest,
  input  logic [DW-1:0] wbData,
  input  issue_strobe_t strobe,
  output logic          fwdHit,
  output logic          predNonZero,
  output logic [DW-1:0] memAddr,
  output logic          commitValid,
  output logic          commitWriteEn,
  output logic [AW-1:0] commitDest,
  output logic          commitIsLoad
);

  logic [DW-1:0] predValue;

  // Extra read port plus bypass from writeback for the predicate.
  always_comb begin
    fwdHit      = wbValid && (wbDest == instPred) && (instPred != '0);
    predValue   = fwdHit ? wbData : predData;
    predNonZero = (predValue != '0);
    memAddr     = baseData;
  end

  logic          pipeValid [LATENCY];
  logic          pipeWe    [LATENCY];
  logic          pipeLoad  [LATENCY];
  logic [AW-1:0] pipeDest  [LATENCY];

  for (genvar s = 0; s < LATENCY; s++) begin : g_stage
    if (s == 0) begin : g_head
      always_ff @(posedge clk) begin
        if (!rstN) begin
          pipeValid[s] <= 1'b0;
          pipeWe[s]    <= 1'b0;
          pipeLoad[s]  <= 1'b0;
          pipeDest[s]  <= '0;
        end else begin
          pipeValid[s] <= strobe.fire;
          pipeWe[s]    <= strobe.exec;
          pipeLoad[s]  <= strobe.isLoad;
          pipeDest[s]  <= strobe.fire ? instDest : '0;
        end
      end
    end else begin : g_body
      always_ff @(posedge clk) begin
        if (!rstN) begin
          pipeValid[s] <= 1'b0;
          pipeWe[s]    <= 1'b0;
          pipeLoad[s]  <= 1'b0;
          pipeDest[s]  <= '0;
        end else begin
          pipeValid[s] <= pipeValid[s-1];
          pipeWe[s]    <= pipeWe[s-1];
          pipeLoad[s]  <= pipeLoad[s-1];
          pipeDest[s]  <= pipeDest[s-1];
        end
      end
    end
  end

  assign commitValid   = pipeValid[LATENCY-1];
  assign commitWriteEn = pipeWe[LATENCY-1];
  assign commitIsLoad  = pipeLoad[LATENCY-1];
  assign commitDest    = pipeDest[LATENCY-1];

endmodule

// File: rtl/pred_issue_stage.sv
module pred_issue_stage
  import pred_issue_pkg::*;
#(
  parameter int REGS    = 32,
  parameter int DW      = 32,
  parameter int LATENCY = 3,
  localparam int AW = $clog2(REGS)
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            instValid,
  input  logic            instIsLoad,
  input  logic [AW-1:0]   instDest,
  input  logic [AW-1:0]   instSrcA,
  input  logic [AW-1:0]   instSrcB,
  input  logic [AW-1:0]   instPred,
  input  logic [REGS-1:0] busyVec,
  input  logic [DW-1:0]   predData,
  input  logic [DW-1:0]   baseData,
  input  logic            wbValid,
  input  logic [AW-1:0]   wbDest,
  input  logic [DW-1:0]   wbData,
  output logic            stall,
  output logic            issueFire,
  output logic            aluEnable,
  output logic            memReadEn,
  output logic [DW-1:0]   memAddr,
  output logic            commitValid,
  output logic            commitWriteEn,
  output logic [AW-1:0]   commitDest,
  output logic            commitIsLoad
);

  issue_strobe_t strobe;
  logic          fwdHit;
  logic          predNonZero;

  pred_issue_ctrl #(.REGS(REGS)) u_ctrl (
    .instValid  (instValid),
    .instIsLoad (instIsLoad),
    .instSrcA   (instSrcA),
    .instSrcB   (instSrcB),
    .instPred   (instPred),
    .busyVec    (busyVec),
    .fwdHit     (fwdHit),
    .predNonZero(predNonZero),
    .stall      (stall),
    .strobe     (strobe)
  );

  pred_issue_dpath #(.REGS(REGS), .DW(DW), .LATENCY(LATENCY)) u_dpath (
    .clk          (clk),
    .rstN         (rstN),
    .instDest     (instDest),
    .instPred     (instPred),
    .predData     (predData),
    .baseData     (baseData),
    .wbValid      (wbValid),
    .wbDest       (wbDest),
    .wbData       (wbData),
    .strobe       (strobe),
    .fwdHit       (fwdHit),
    .predNonZero  (predNonZero),
    .memAddr      (memAddr),
    .commitValid  (commitValid),
    .commitWriteEn(commitWriteEn),
    .commitDest   (commitDest),
    .commitIsLoad (commitIsLoad)
  );

  assign issueFire = strobe.fire;
  assign aluEnable = strobe.exec && !strobe.isLoad;
  assign memReadEn = strobe.exec && strobe.isLoad;

endmodule

// File: rtl/pred_issue_sva.sv
module pred_issue_sva #(
  parameter int REGS = 32,
  localparam int AW = $clog2(REGS)
) (
  input logic            clk,
  input logic            rstN,
  input logic            instValid,
  input logic            instIsLoad,
  input logic [AW-1:0]   instPred,
  input logic [REGS-1:0] busyVec,
  input logic            wbValid,
  input logic [AW-1:0]   wbDest,
  input logic            stall,
  input logic            issueFire,
  input logic            aluEnable,
  input logic            memReadEn,
  input logic            commitValid,
  input logic            commitWriteEn,
  input logic            commitIsLoad
);

  // R3: a held instruction does nothing
  assert_stall_quiet_R3: assert property (@(posedge clk) disable iff (!rstN)
    stall |-> !issueFire && !aluEnable && !memReadEn);

  // R3: pending, unforwarded predicate always holds the stage
  assert_pending_pred_R3: assert property (@(posedge clk) disable iff (!rstN)
    (instValid && instPred != '0 && busyVec[instPred] && !(wbValid && wbDest == instPred))
      |-> stall);

  // R9: no instruction, no activity
  assert_idle_R9: assert property (@(posedge clk) disable iff (!rstN)
    !instValid |-> !stall && !issueFire && !aluEnable && !memReadEn);

  // R5: predicate register 0 never stalls and never executes
  assert_zero_pred_R5: assert property (@(posedge clk) disable iff (!rstN)
    (instValid && instPred == '0) |-> !stall && issueFire && !aluEnable && !memReadEn);

  // R1: enables match the instruction kind
  assert_kind_R1: assert property (@(posedge clk) disable iff (!rstN)
    (memReadEn |-> issueFire && instIsLoad) and (aluEnable |-> issueFire && !instIsLoad));

  // R7: a write at commit belongs to an issued slot
  assert_commit_slot_R7: assert property (@(posedge clk) disable iff (!rstN)
    (commitWriteEn || commitIsLoad) |-> commitValid);

  // R8: commit slot empty on the first cycle after reset
  assert_reset_clear_R8: assert property (@(posedge clk)
    $rose(rstN) |-> !commitValid && !commitWriteEn && !commitIsLoad);

endmodule

bind pred_issue_stage pred_issue_sva #(.REGS(REGS)) u_sva (
  .clk          (clk),
  .rstN         (rstN),
  .instValid    (instValid),
  .instIsLoad   (instIsLoad),
  .instPred     (instPred),
  .busyVec      (busyVec),
  .wbValid      (wbValid),
  .wbDest       (wbDest),
  .stall        (stall),
  .issueFire    (issueFire),
  .aluEnable    (aluEnable),
  .memReadEn    (memReadEn),
  .commitValid  (commitValid),
  .commitWriteEn(commitWriteEn),
  .commitIsLoad (commitIsLoad)
);

// File: tb/sim_pred_issue_stage.sv
module sim_pred_issue_stage;

  localparam int REGS = 4;
  localparam int DW   = 4;
  localparam int LAT  = 2;
  localparam int AW   = $clog2(REGS);

  logic            clk = 1'b0;
  logic            rstN = 1'b0;
  logic            instValid = 1'b0;
  logic            instIsLoad = 1'b0;
  logic [AW-1:0]   instDest = '0;
  logic [AW-1:0]   instSrcA = '0;
  logic [AW-1:0]   instSrcB = '0;
  logic [AW-1:0]   instPred = '0;
  logic [REGS-1:0] busyVec = '0;
  logic [DW-1:0]   predData = '0;
  logic [DW-1:0]   baseData = '0;
  logic            wbValid = 1'b0;
  logic [AW-1:0]   wbDest = '0;
  logic [DW-1:0]   wbData = '0;
  logic            stall, issueFire, aluEnable, memReadEn;
  logic [DW-1:0]   memAddr;
  logic            commitValid, commitWriteEn, commitIsLoad;
  logic [AW-1:0]   commitDest;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;  // 50 MHz

  pred_issue_stage #(.REGS(REGS), .DW(DW), .LATENCY(LAT)) u0 (.*);

  // expected commit history, one entry per clock edge
  logic          hValid [LAT];
  logic          hWe    [LAT];
  logic          hLoad  [LAT];
  logic [AW-1:0] hDest  [LAT];

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic checkCommit(input string req);
    check(commitValid === hValid[LAT-1], req, "commitValid", int'(commitValid), int'(hValid[LAT-1]));
    check(commitWriteEn === hWe[LAT-1], req, "commitWriteEn", int'(commitWriteEn), int'(hWe[LAT-1]));
    check(commitIsLoad === hLoad[LAT-1], req, "commitIsLoad", int'(commitIsLoad), int'(hLoad[LAT-1]));
    check(commitDest === hDest[LAT-1], req, "commitDest", int'(commitDest), int'(hDest[LAT-1]));
  endtask

  initial begin
    for (int i = 0; i < LAT; i++) begin
      hValid[i] = 0; hWe[i] = 0; hLoad[i] = 0; hDest[i] = '0;
    end
  end

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : stim
    int n = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    checkCommit("R8");
    rstN = 1'b1;
    for (int ld = 0; ld < 2; ld++)
    for (int pr = 0; pr < REGS; pr++)
    for (int bv = 0; bv < (1 << REGS); bv++)
    for (int pv = 0; pv < 2; pv++)
    for (int wv = 0; wv < 2; wv++)
    for (int wd = 0; wd < REGS; wd++)
    for (int wx = 0; wx < 2; wx++)
    for (int sa = 0; sa < REGS; sa++) begin
      bit valid, fwd, pTrue, pPend, sPend, expStall, expFire, expExec;
      logic [AW-1:0] sb;
      logic [DW-1:0] pVal;
      string req;
      @(negedge clk);
      sb = AW'(REGS - 1 - sa);
      valid = (n % 5) != 4;
      n++;
      instValid = valid; instIsLoad = ld[0]; instPred = AW'(pr);
      instSrcA = AW'(sa); instSrcB = sb; instDest = AW'(sa + pr);
      busyVec = REGS'(bv); predData = pv ? DW'(6) : '0;
      baseData = DW'(sa * 3 + pr); wbValid = wv[0]; wbDest = AW'(wd);
      wbData = wx ? DW'(9) : '0;
      // expected values from the requirements
      fwd   = wv[0] && (wd == pr) && (pr != 0);                 // R4
      pVal  = fwd ? wbData : predData;
      pTrue = (pr != 0) && (pVal != 0);                          // R5
      pPend = (pr != 0) && busyVec[pr] && !fwd;                  // R3
      sPend = ((sa != 0) && busyVec[sa]) ||
              (!ld[0] && (sb != 0) && busyVec[sb]);              // R6
      expStall = valid && (pPend || (pTrue && sPend));
      expFire  = valid && !expStall;
      expExec  = expFire && pTrue;
      req = !valid ? "R9" : pPend ? (fwd ? "R4" : "R3") : (pr == 0) ? "R5" :
            (pTrue && sPend) ? "R6" : pTrue ? "R1" : "R2";
      #1;
      check(stall === expStall, req, "stall", int'(stall), int'(expStall));
      check(issueFire === expFire, req, "issueFire", int'(issueFire), int'(expFire));
      check(aluEnable === (expExec && !ld[0]), req, "aluEnable", int'(aluEnable), int'(expExec && !ld[0]));
      check(memReadEn === (expExec && ld[0]), req, "memReadEn", int'(memReadEn), int'(expExec && ld[0]));
      if (expExec && ld[0])
        check(memAddr === baseData, "R1", "memAddr", int'(memAddr), int'(baseData));
      checkCommit("R7");
      @(posedge clk);
      for (int i = LAT - 1; i > 0; i--) begin
        hValid[i] = hValid[i-1]; hWe[i] = hWe[i-1];
        hLoad[i] = hLoad[i-1]; hDest[i] = hDest[i-1];
      end
      hValid[0] = expFire; hWe[0] = expExec;
      hLoad[0] = expFire && ld[0]; hDest[0] = expFire ? AW'(sa + pr) : '0;
    end
    // drain: idle slots must commit empty (R7)
    for (int k = 0; k < LAT + 2; k++) begin
      @(negedge clk);
      instValid = 1'b0;
      #1;
      checkCommit("R7");
      check(stall === 1'b0 && issueFire === 1'b0, "R9", "idle", int'({stall, issueFire}), 0);
      @(posedge clk);
      for (int i = LAT - 1; i > 0; i--) begin
        hValid[i] = hValid[i-1]; hWe[i] = hWe[i-1];
        hLoad[i] = hLoad[i-1]; hDest[i] = hDest[i-1];
      end
      hValid[0] = 0; hWe[0] = 0; hLoad[0] = 0; hDest[0] = '0;
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule